// File: doc/BRIEF.md
# Debug-Probe Serial Frame Transmitter

This block assembles outgoing command packets for a byte-oriented debug-probe link. A host-side agent offers a request carrying the body length. Once the request is taken, the agent streams the body bytes over a valid/ready channel. The block puts a complete frame on a byte-wide valid/ready transmit channel. A frame holds a start marker, an automatically assigned sequence number, the little-endian length, a token byte, the body and a 16-bit checksum.

The checksum is a reflected CCITT CRC with an all-ones preset and no final inversion. It covers every byte from the start marker onward and is sent low byte first. The sequence counter starts at zero, moves forward by one after each completed frame and wraps at its width. The value used by the most recent finished frame stays visible, so a receiver can match the echoed number in a reply. A body stream that ends before the announced length closes the frame early and raises a sticky error flag.

Top module: `probe_frame_tx`

## Requirements
- R1: Each frame leaves in this order: 0x1B, the sequence number (SEQ_W/8 bytes, least significant first), the length field, the token 0x0E, the body bytes, then the two CRC bytes.
- R2: The CRC is the reflected form of polynomial 0x1021 (bitwise step with 0x8408), preset 0xFFFF, no output XOR, computed over every byte before it starting at 0x1B, and sent low byte then high byte. Body 03 06 at sequence 1, 2 and 3 ends in 96 76, 91 A0 and 6C ED. Body 01 at sequence 0 ends in F3 97.
- R3: The sequence number is 0 after reset and grows by one per completed frame, wrapping from all ones to 0.
- R4: last_seq shows the sequence number of the most recent completed frame (0 after reset). It changes in the same clock edge in which the final CRC byte is accepted, and at no other time.
- R5: The length field is req_len sent as 4 bytes, least significant first. A zero length puts the CRC right after the token.
- R6: body_ready is low outside the body phase, so body bytes offered during the header are neither consumed nor transmitted before the token.
- R7: body_last arriving before the announced count ends the body. The CRC then covers only the bytes sent, and err_short goes high and stays high until the next request is accepted.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged on the next cycle.
- R9: req_ready is high only when no frame is in progress. An accepted request drops req_ready until its frame's last byte has been accepted.
- R10: During and right after reset: tx_valid low, req_ready high, body_ready low, last_seq 0, err_short low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New frame request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_len | input | LEN_W | Body length in bytes for the request |
| body_valid | input | 1 | Body byte offered |
| body_ready | output | 1 | Body byte taken this cycle |
| body_data | input | 8 | Body byte |
| body_last | input | 1 | Marks the final body byte the source will send |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Transmit byte |
| last_seq | output | SEQ_W | Sequence number of the last completed frame |
| err_short | output | 1 | Body ended before the announced length |

## Verification
The bench checks every transmitted byte against a frame built from the length, the body and a separately computed CRC. It sweeps body lengths 0 to 12 under three downstream stall patterns. A block that counted a length byte wrongly, or that updated the CRC on a stalled byte or on its own CRC bytes, would shift or corrupt the stream. The known sign-on and 03 06 frames catch a wrong preset, a wrong reflection or a swapped CRC byte order. Early body ends are checked for the error flag and for a CRC that covers only the bytes actually sent. A narrow second instance runs past its sequence wrap, where a counter that saturated or advanced at frame start would put the wrong number in the frame.

// File: rtl/probe_tx_pkg.sv
package probe_tx_pkg;

    localparam logic [7:0]  SOF_BYTE      = 8'h1B;
    localparam logic [7:0]  TOKEN_BYTE    = 8'h0E;
    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_SEQ,
        PH_LEN,
        PH_TOKEN,
        PH_BODY,
        PH_CRC,
        PH_DONE
    } phase_e;

    // one candidate byte for the output register
    typedef struct packed {
        logic       valid;
        logic       crc_en;
        logic [7:0] data;
    } byte_slot_t;

    // reflected CRC update for one byte, LSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [7:0]  b);
        logic [15:0] c;
        c = c_in ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/probe_crc16.sv
module probe_crc16
    import probe_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= CRC_PRESET;
        end else if (en) begin
            crc <= crc16_step(crc, din);
        end
    end

endmodule

// File: rtl/probe_seq_ctr.sv
module probe_seq_ctr #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [SEQ_W-1:0] cur,
    output logic [SEQ_W-1:0] last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            last <= '0;
        end else if (step) begin
            last <= cur;
            cur  <= cur + 1'b1;
        end
    end

endmodule

// File: rtl/probe_frame_seq.sv
module probe_frame_seq
    import probe_tx_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic             body_valid,
    input  logic [7:0]       body_data,
    input  logic             body_last,
    output logic             body_ready,
    input  logic             slot_free,
    input  logic             final_taken,
    input  logic [SEQ_W-1:0] seq_cur,
    input  logic [15:0]      crc_val,
    output byte_slot_t       nxt,
    output logic             crc_init,
    output logic             seq_step,
    output logic             err_short,
    output phase_e           ph
);

    localparam int SEQ_BYTES = (SEQ_W + 7) / 8;
    localparam int LEN_BYTES = (LEN_W + 7) / 8;
    localparam int MAXB      = (SEQ_BYTES > LEN_BYTES) ? SEQ_BYTES : LEN_BYTES;
    localparam int IDX_W     = (MAXB > 1) ? $clog2(MAXB) : 1;

    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  left;
    logic [MAXB*8-1:0] seq_pad;
    logic [MAXB*8-1:0] len_pad;
    logic              advance;

    always_comb begin
        seq_pad = '0;
        seq_pad[SEQ_W-1:0] = seq_cur;
        len_pad = '0;
        len_pad[LEN_W-1:0] = len_q;
    end

    always_comb begin
        nxt        = '0;
        body_ready = 1'b0;
        unique case (ph)
            PH_START: nxt = '{valid: 1'b1, crc_en: 1'b1, data: SOF_BYTE};
            PH_SEQ:   nxt = '{valid: 1'b1, crc_en: 1'b1, data: seq_pad[{idx, 3'b000} +: 8]};
            PH_LEN:   nxt = '{valid: 1'b1, crc_en: 1'b1, data: len_pad[{idx, 3'b000} +: 8]};
            PH_TOKEN: nxt = '{valid: 1'b1, crc_en: 1'b1, data: TOKEN_BYTE};
            PH_BODY: begin
                nxt        = '{valid: body_valid, crc_en: 1'b1, data: body_data};
                body_ready = slot_free;
            end
            PH_CRC:   nxt = '{valid: 1'b1, crc_en: 1'b0,
                              data: (idx == '0) ? crc_val[7:0] : crc_val[15:8]};
            default:  nxt = '0;
        endcase
    end

    assign advance   = slot_free && nxt.valid;
    assign req_ready = (ph == PH_IDLE);
    assign crc_init  = (ph == PH_IDLE) && req_valid;
    assign seq_step  = (ph == PH_DONE) && final_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            idx       <= '0;
            len_q     <= '0;
            left      <= '0;
            err_short <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: if (req_valid) begin
                    len_q     <= req_len;
                    left      <= req_len;
                    err_short <= 1'b0;
                    ph        <= PH_START;
                end
                PH_START: if (advance) begin
                    idx <= '0;
                    ph  <= PH_SEQ;
                end
                PH_SEQ: if (advance) begin
                    if (idx == IDX_W'(SEQ_BYTES - 1)) begin
                        idx <= '0;
                        ph  <= PH_LEN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_LEN: if (advance) begin
                    if (idx == IDX_W'(LEN_BYTES - 1)) begin
                        idx <= '0;
                        ph  <= PH_TOKEN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_TOKEN: if (advance) begin
                    idx <= '0;
                    ph  <= (len_q == '0) ? PH_CRC : PH_BODY;
                end
                PH_BODY: if (advance) begin
                    left <= left - 1'b1;
                    if (left == LEN_W'(1) || body_last) begin
                        ph <= PH_CRC;
                    end
                    if (body_last && left != LEN_W'(1)) begin
                        err_short <= 1'b1;
                    end
                end
                PH_CRC: if (advance) begin
                    if (idx == '0) begin
                        idx <= IDX_W'(1);
                    end else begin
                        idx <= '0;
                        ph  <= PH_DONE;
                    end
                end
                PH_DONE: if (final_taken) begin
                    ph <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/probe_frame_tx.sv
module probe_frame_tx
    import probe_tx_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LEN_W-1:0] req_len,
    input  logic             body_valid,
    output logic             body_ready,
    input  logic [7:0]       body_data,
    input  logic             body_last,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic [SEQ_W-1:0] last_seq,
    output logic             err_short
);

    logic             slot_free;
    logic             final_taken;
    byte_slot_t       nxt;
    logic [15:0]      crc_val;
    logic             crc_init;
    logic             seq_step;
    logic [SEQ_W-1:0] seq_cur;
    phase_e           ph;

    assign slot_free   = !tx_valid || tx_ready;
    assign final_taken = tx_valid && tx_ready;

    probe_frame_seq #(.SEQ_W(SEQ_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_len     (req_len),
        .req_ready   (req_ready),
        .body_valid  (body_valid),
        .body_data   (body_data),
        .body_last   (body_last),
        .body_ready  (body_ready),
        .slot_free   (slot_free),
        .final_taken (final_taken),
        .seq_cur     (seq_cur),
        .crc_val     (crc_val),
        .nxt         (nxt),
        .crc_init    (crc_init),
        .seq_step    (seq_step),
        .err_short   (err_short),
        .ph          (ph)
    );

    probe_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .en   (slot_free && nxt.valid && nxt.crc_en),
        .din  (nxt.data),
        .crc  (crc_val)
    );

    probe_seq_ctr #(.SEQ_W(SEQ_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .step (seq_step),
        .cur  (seq_cur),
        .last (last_seq)
    );

    // output holding register: loads only when empty or being drained
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (slot_free) begin
            tx_valid <= nxt.valid;
            if (nxt.valid) begin
                tx_data <= nxt.data;
            end
        end
    end

endmodule

// File: rtl/probe_frame_tx_chk.sv
module probe_frame_tx_chk #(
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             body_valid,
    input logic             body_ready,
    input logic             body_last,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             err_short,
    input logic [SEQ_W-1:0] last_seq,
    input logic [SEQ_W-1:0] seq_cur
);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_body_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (body_valid && body_ready) |=> tx_valid);

    assert_req_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_cur != $past(seq_cur)) |-> (seq_cur == SEQ_W'($past(seq_cur) + 1'b1)));

    assert_last_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_cur != $past(seq_cur)) |-> (last_seq == $past(seq_cur)));

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_short) |-> $past(body_valid && body_ready && body_last));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!tx_valid && req_ready && !err_short));

endmodule

bind probe_frame_tx probe_frame_tx_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .body_valid (body_valid),
    .body_ready (body_ready),
    .body_last  (body_last),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .err_short  (err_short),
    .last_seq   (last_seq),
    .seq_cur    (seq_cur)
);

// File: tb/tb_probe_frame_tx.sv
module tb_probe_frame_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_len = '0;
    logic        body_valid = 1'b0;
    logic        body_ready;
    logic [7:0]  body_data = '0;
    logic        body_last = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic [15:0] last_seq;
    logic        err_short;

    // narrow instance used to reach the sequence wrap quickly
    logic        req_valid_s = 1'b0;
    logic        req_ready_s;
    logic        body_ready_s;
    logic        tx_valid_s;
    logic [7:0]  tx_data_s;
    logic [7:0]  last_seq_s;
    logic        err_short_s;

    always #4 clk = ~clk;

    probe_frame_tx #(.SEQ_W(16), .LEN_W(32)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_len(req_len), .body_valid(body_valid), .body_ready(body_ready),
        .body_data(body_data), .body_last(body_last), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .last_seq(last_seq),
        .err_short(err_short)
    );

    probe_frame_tx #(.SEQ_W(8), .LEN_W(32)) dut_small (
        .clk(clk), .rst(rst), .req_valid(req_valid_s), .req_ready(req_ready_s),
        .req_len(32'd0), .body_valid(1'b0), .body_ready(body_ready_s),
        .body_data(8'h00), .body_last(1'b0), .tx_valid(tx_valid_s),
        .tx_ready(1'b1), .tx_data(tx_data_s), .last_seq(last_seq_s),
        .err_short(err_short_s)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0]  bsrc [0:31];
    logic [7:0]  expb [0:63];
    logic [7:0]  cap  [0:63];
    int          cap_n;
    logic [15:0] exp_seq  = 16'd0;
    logic [15:0] prev_last = 16'd0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {8'h00, expb[i]};
            for (int j = 0; j < 8; j++) begin
                if (c[0]) c = (c >> 1) ^ 16'h8408;
                else      c = c >> 1;
            end
        end
        return c;
    endfunction

    // early < 0: body runs to its full length
    task automatic run_frame(input int len, input int early, input int stall);
        int nb, n, k, bi, cyc;
        bit prev_hold, last_bad;
        logic [7:0] prevd;
        logic [15:0] c;
        nb = (early >= 0 && early < len - 1) ? early + 1 : len;
        expb[0] = 8'h1B;
        expb[1] = exp_seq[7:0];
        expb[2] = exp_seq[15:8];
        for (int i = 0; i < 4; i++) expb[3+i] = 8'(len >> (8*i));
        expb[7] = 8'h0E;
        for (int i = 0; i < nb; i++) expb[8+i] = bsrc[i];
        n = 8 + nb;
        c = ref_crc(n);
        expb[n]   = c[7:0];
        expb[n+1] = c[15:8];
        n = n + 2;

        @(negedge clk);
        req_valid = 1'b1;
        req_len   = len;
        tx_ready  = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(req_ready == 1'b0, "R9 busy", req_ready, 0);
        chk(err_short == 1'b0, "R7 err cleared on accept", err_short, 0);

        k = 0; bi = 0; cyc = 0; prev_hold = 0; prevd = '0; last_bad = 0;
        while (k < n && cyc < 2000) begin
            tx_ready   = (stall == 0) ? 1'b1 : (((cyc * 7 + stall) % 3) != 0);
            body_valid = (bi < nb);
            body_data  = (bi < nb) ? bsrc[bi] : 8'h00;
            body_last  = (bi == nb - 1);
            #1;
            if (prev_hold)
                chk(tx_valid && tx_data == prevd, "R8 hold", {tx_valid, tx_data}, {1'b1, prevd});
            if (k < 7 && body_ready)
                chk(1'b0, "R6 body_ready during header", body_ready, 0);
            if (last_seq != prev_last) last_bad = 1;
            if (tx_valid && tx_ready) begin
                if (k < 3 || k == 7)
                    chk(tx_data == expb[k], "R1 header byte", tx_data, expb[k]);
                else if (k < 7)
                    chk(tx_data == expb[k], "R5 length byte", tx_data, expb[k]);
                else if (k >= n - 2)
                    chk(tx_data == expb[k], "R2 crc byte", tx_data, expb[k]);
                else
                    chk(tx_data == expb[k], "R6 body byte", tx_data, expb[k]);
                cap[k] = tx_data;
                k++;
            end
            prev_hold = tx_valid && !tx_ready;
            prevd     = tx_data;
            if (body_valid && body_ready) bi++;
            cyc++;
            @(negedge clk);
        end
        cap_n = k;
        tx_ready   = 1'b0;
        body_valid = 1'b0;
        body_last  = 1'b0;
        #1;
        chk(k == n, "R1 frame byte count", k, n);
        chk(!last_bad, "R4 last_seq stable mid-frame", last_bad, 0);
        chk(last_seq == exp_seq, "R4 last_seq after frame", last_seq, exp_seq);
        chk(req_ready == 1'b1, "R9 idle after frame", req_ready, 1);
        chk(tx_valid == 1'b0, "R1 nothing after crc", tx_valid, 0);
        chk(err_short == (nb != len), "R7 err flag", err_short, (nb != len));
        prev_last = exp_seq;
        exp_seq   = exp_seq + 1'b1;
    endtask

    // small instance monitor: 9-byte frames, seq byte at offset 1
    bit small_on = 1'b0;
    int spos = 0;
    int sfno = 0;
    always @(negedge clk) begin
        if (small_on && tx_valid_s) begin
            if (spos == 0)
                chk(tx_data_s == 8'h1B, "R1 small start", tx_data_s, 8'h1B);
            if (spos == 1)
                chk(tx_data_s == 8'(sfno), "R3 small seq wrap", tx_data_s, 8'(sfno));
            if (spos == 8) begin
                spos = 0;
                sfno++;
            end else begin
                spos++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(tx_valid == 1'b0, "R10 tx_valid in reset", tx_valid, 0);
        chk(req_ready == 1'b1, "R10 req_ready in reset", req_ready, 1);
        chk(body_ready == 1'b0, "R10 body_ready in reset", body_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(last_seq == 16'd0, "R10 last_seq", last_seq, 0);
        chk(err_short == 1'b0, "R10 err_short", err_short, 0);
        chk(tx_valid == 1'b0, "R10 tx idle", tx_valid, 0);

        // known vectors
        bsrc[0] = 8'h01;
        run_frame(1, -1, 0);
        chk({cap[cap_n-2], cap[cap_n-1]} == 16'hF397, "R2 sign-on crc",
            {cap[cap_n-2], cap[cap_n-1]}, 16'hF397);
        bsrc[0] = 8'h03; bsrc[1] = 8'h06;
        run_frame(2, -1, 0);
        chk({cap[cap_n-2], cap[cap_n-1]} == 16'h9676, "R2 seq1 crc",
            {cap[cap_n-2], cap[cap_n-1]}, 16'h9676);
        run_frame(2, -1, 1);
        chk({cap[cap_n-2], cap[cap_n-1]} == 16'h91A0, "R2 seq2 crc",
            {cap[cap_n-2], cap[cap_n-1]}, 16'h91A0);
        run_frame(2, -1, 2);
        chk({cap[cap_n-2], cap[cap_n-1]} == 16'h6CED, "R2 seq3 crc",
            {cap[cap_n-2], cap[cap_n-1]}, 16'h6CED);

        // sweep lengths (R5 zero length included) and stall patterns (R8)
        for (int len = 0; len <= 12; len++) begin
            for (int st = 0; st < 3; st++) begin
                for (int i = 0; i < 32; i++) bsrc[i] = 8'(i * 29 + len * 3 + st);
                run_frame(len, -1, st);
            end
        end

        // early end of body (R7)
        for (int i = 0; i < 32; i++) bsrc[i] = 8'(i * 13 + 7);
        run_frame(8, 0, 0);
        run_frame(8, 3, 1);
        run_frame(5, 3, 2);
        run_frame(3, -1, 1);

        // sequence wrap on the narrow instance (R3)
        small_on    = 1'b1;
        req_valid_s = 1'b1;
        while (sfno < 260) @(negedge clk);
        req_valid_s = 1'b0;
        small_on    = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule